// File: doc/BRIEF.md
# Exception and Interrupt Entry Sequencer

This block performs the register updates a processor core needs when it takes a synchronous exception or a hardware interrupt. The core presents the pending event together with its current status register, program counter, vector base and stack register R15, plus flags that say whether it is executing a delay-slot instruction and whether it is sleeping. In one clock the block decides whether the event is taken. If it is, the block registers the new program counter and the new status register, keeps copies of the old status, PC and R15, and records the event code. An exception that arrives while events are blocked becomes a reset request.

The interrupt mask field of the status register is sent combinationally to an external priority controller. That controller answers with an interrupt code and a flag that says whether any interrupt source is above the mask. The core uses the one-cycle `entry_done` strobe to load the new PC and status register, to clear its sleep flag and to drop any load-locked reservation. It uses `ds_clear` to drop its delay-slot flag.

Top module: `exc_entry_seq`

## Requirements
- R1: When `exc_valid` and `irq_pending` are both high in the same cycle, only the exception is handled. `expevt` is loaded and `intevt` keeps its value.
- R2: If the block bit (status bit 28) is set and an exception with a code other than 0x1E0 arrives, `reset_req` pulses for one cycle one clock later. No entry takes place and every saved register keeps its value. Code 0x1E0 is entered normally even while blocked.
- R3: An interrupt is not taken in these cases: the block bit is set and `asleep` is low; `in_delay_slot` is high; or `irq_code_valid` is low. `irq_mask` always equals status bits 7:4.
- R4: On entry, `ssr` receives the old status register and `sgr` receives R15. `new_sr` is the old status register with bit 28 (block), bit 30 (privileged mode) and bit 29 (register bank) set.
- R5: An event taken with `in_delay_slot` high stores PC−2 in `spc` and pulses `ds_clear` together with `entry_done`. Otherwise `spc` receives the PC and `ds_clear` stays low.
- R6: Exception codes 0x000, 0x020 and 0x140 clear status bit 15 (FPU disable), set status bits 7:4 to 0xF, and jump to 0xA0000000.
- R7: Exception codes 0x040 and 0x060 jump to VBR+0x400. Every other normally entered exception jumps to VBR+0x100. Code 0x160 adds 2 to `spc` after any delay-slot rewind.
- R8: An exception writes its code to `expevt`. An interrupt writes `irq_code` to `intevt` and jumps to VBR+0x600.
- R9: All results appear one clock after the accepting edge. `entry_done` is high for exactly that cycle, and all outputs except the strobes hold until the next accepted event.
- R10: After reset, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| exc_valid | input | 1 | Synchronous exception pending |
| exc_code | input | 12 | Exception code |
| irq_pending | input | 1 | Hardware interrupt pending |
| irq_code | input | 12 | Code from the priority controller |
| irq_code_valid | input | 1 | Controller found an interrupt above the mask |
| irq_mask | output | 4 | Mask level sent to the controller (status bits 7:4) |
| sr_in | input | 32 | Current status register |
| pc_in | input | 32 | Current program counter |
| vbr_in | input | 32 | Vector base |
| r15_in | input | 32 | Current R15 |
| in_delay_slot | input | 1 | Core is in a delay slot |
| asleep | input | 1 | Core is sleeping |
| entry_done | output | 1 | One-cycle strobe: entry completed |
| reset_req | output | 1 | One-cycle strobe: blocked exception, reset needed |
| ds_clear | output | 1 | One-cycle strobe: clear the delay-slot flag |
| new_pc | output | 32 | Handler address |
| new_sr | output | 32 | Updated status register |
| ssr | output | 32 | Saved status register |
| spc | output | 32 | Saved program counter |
| sgr | output | 32 | Saved R15 |
| expevt | output | 12 | Last exception code |
| intevt | output | 12 | Last interrupt code |

## Verification
The hardest case to reach is a blocked core that is asleep while an interrupt and a delay-slot flag are both present. Here the sleep exception to blocking and the delay-slot veto on interrupts act against each other. The bench reaches it by sweeping every combination of block bit, sleep, delay slot and controller-valid for interrupts. It also sweeps a set of exception codes against block bit and delay slot, with an interrupt pending at the same time. After each event it runs an idle cycle to confirm that the saved values hold.

// File: rtl/exc_entry_seq.sv
module exc_entry_seq #(
  parameter int XLEN     = 32,
  parameter int CODE_W   = 12,
  parameter int BL_BIT   = 28,
  parameter int RB_BIT   = 29,
  parameter int MD_BIT   = 30,
  parameter int FD_BIT   = 15,
  parameter int IMASK_LO = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              exc_valid,
  input  logic [CODE_W-1:0] exc_code,
  input  logic              irq_pending,
  input  logic [CODE_W-1:0] irq_code,
  input  logic              irq_code_valid,
  output logic [3:0]        irq_mask,
  input  logic [XLEN-1:0]   sr_in,
  input  logic [XLEN-1:0]   pc_in,
  input  logic [XLEN-1:0]   vbr_in,
  input  logic [XLEN-1:0]   r15_in,
  input  logic              in_delay_slot,
  input  logic              asleep,
  output logic              entry_done,
  output logic              reset_req,
  output logic              ds_clear,
  output logic [XLEN-1:0]   new_pc,
  output logic [XLEN-1:0]   new_sr,
  output logic [XLEN-1:0]   ssr,
  output logic [XLEN-1:0]   spc,
  output logic [XLEN-1:0]   sgr,
  output logic [CODE_W-1:0] expevt,
  output logic [CODE_W-1:0] intevt
);
  localparam logic [CODE_W-1:0] C_UNBLOCKED = CODE_W'('h1E0);
  localparam logic [CODE_W-1:0] C_POWERON   = CODE_W'('h000);
  localparam logic [CODE_W-1:0] C_MANUAL    = CODE_W'('h020);
  localparam logic [CODE_W-1:0] C_MULTIHIT  = CODE_W'('h140);
  localparam logic [CODE_W-1:0] C_MISS_RD   = CODE_W'('h040);
  localparam logic [CODE_W-1:0] C_MISS_WR   = CODE_W'('h060);
  localparam logic [CODE_W-1:0] C_TRAP      = CODE_W'('h160);
  localparam logic [XLEN-1:0]   RESET_VEC   = XLEN'('hA000_0000);
  localparam logic [XLEN-1:0]   OFS_GEN     = XLEN'('h100);
  localparam logic [XLEN-1:0]   OFS_MISS    = XLEN'('h400);
  localparam logic [XLEN-1:0]   OFS_IRQ     = XLEN'('h600);
  localparam logic [XLEN-1:0]   TWO         = XLEN'(2);

  logic blocked, exc_blocked, take_exc, take_irq, accept, rst_class, miss_class, trap;
  logic [XLEN-1:0] sr_set, sr_rst, pc_next, spc_next;

  assign irq_mask    = sr_in[IMASK_LO +: 4];
  assign blocked     = sr_in[BL_BIT];
  assign exc_blocked = exc_valid && blocked && (exc_code != C_UNBLOCKED);
  assign take_exc    = exc_valid && !exc_blocked;
  assign take_irq    = !exc_valid && irq_pending && irq_code_valid &&
                       !in_delay_slot && (!blocked || asleep);
  assign accept      = take_exc || take_irq;

  assign rst_class  = (exc_code == C_POWERON) || (exc_code == C_MANUAL) || (exc_code == C_MULTIHIT);
  assign miss_class = (exc_code == C_MISS_RD) || (exc_code == C_MISS_WR);
  assign trap       = exc_code == C_TRAP;

  always_comb begin
    sr_set = sr_in;
    sr_set[BL_BIT] = 1'b1;
    sr_set[MD_BIT] = 1'b1;
    sr_set[RB_BIT] = 1'b1;
    sr_rst = sr_set;
    sr_rst[FD_BIT] = 1'b0;
    sr_rst[IMASK_LO +: 4] = 4'hF;
    spc_next = pc_in - (in_delay_slot ? TWO : '0) + ((take_exc && trap) ? TWO : '0);
    if (!take_exc)       pc_next = vbr_in + OFS_IRQ;
    else if (rst_class)  pc_next = RESET_VEC;
    else if (miss_class) pc_next = vbr_in + OFS_MISS;
    else                 pc_next = vbr_in + OFS_GEN;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      entry_done <= 1'b0;
      reset_req  <= 1'b0;
      ds_clear   <= 1'b0;
      new_pc     <= '0;
      new_sr     <= '0;
      ssr        <= '0;
      spc        <= '0;
      sgr        <= '0;
      expevt     <= '0;
      intevt     <= '0;
    end else begin
      entry_done <= accept;
      reset_req  <= exc_blocked;
      ds_clear   <= accept && in_delay_slot;
      if (accept) begin
        ssr    <= sr_in;
        sgr    <= r15_in;
        spc    <= spc_next;
        new_pc <= pc_next;
        new_sr <= (take_exc && rst_class) ? sr_rst : sr_set;
        if (take_exc) expevt <= exc_code;
        else          intevt <= irq_code;
      end
    end
  end

  p_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(entry_done && reset_req));
  p_block_r2: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |-> $stable(spc) && $stable(ssr));
  p_ds_irq_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!exc_valid && in_delay_slot) |=> !entry_done);
  p_bits_r4: assert property (@(posedge clk) disable iff (!rst_n)
    entry_done |-> new_sr[BL_BIT] && new_sr[MD_BIT] && new_sr[RB_BIT]);
  p_resetvec_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (entry_done && new_pc == RESET_VEC && !$stable(expevt)) |-> new_sr[IMASK_LO +: 4] == 4'hF);
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !entry_done |-> $stable(ssr) && $stable(sgr) && $stable(new_pc));
  p_dsclr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ds_clear |-> entry_done);
endmodule

// File: tb/sim_exc_entry_seq.sv
module sim_exc_entry_seq;
  logic clk = 0, rst_n = 0;
  logic exc_valid = 0, irq_pending = 0, irq_code_valid = 0, in_delay_slot = 0, asleep = 0;
  logic [11:0] exc_code = 0, irq_code = 0;
  logic [31:0] sr_in = 0, pc_in = 0, vbr_in = 0, r15_in = 0;
  logic [3:0] irq_mask;
  logic entry_done, reset_req, ds_clear;
  logic [31:0] new_pc, new_sr, ssr, spc, sgr;
  logic [11:0] expevt, intevt;

  int n_chk = 0, n_bad = 0;
  logic [31:0] e_pc = 0, e_sr = 0, e_ssr = 0, e_spc = 0, e_sgr = 0;
  logic [11:0] e_exp = 0, e_int = 0;

  always #2 clk = ~clk;

  exc_entry_seq u0 (.*);

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic check_all(logic e_done, logic e_rr, logic e_ds);
    chk("R9", "entry_done", 32'(entry_done), 32'(e_done));
    chk("R2", "reset_req", 32'(reset_req), 32'(e_rr));
    chk("R5", "ds_clear", 32'(ds_clear), 32'(e_ds));
    chk("R7", "new_pc", new_pc, e_pc);
    chk("R6", "new_sr", new_sr, e_sr);
    chk("R4", "ssr", ssr, e_ssr);
    chk("R5", "spc", spc, e_spc);
    chk("R4", "sgr", sgr, e_sgr);
    chk("R8", "expevt", 32'(expevt), 32'(e_exp));
    chk("R1", "intevt", 32'(intevt), 32'(e_int));
  endtask

  // apply one event, predict, check one cycle later, then an idle hold cycle
  task automatic event_step(logic ev, logic [11:0] ec, logic ip, logic [11:0] ic, logic icv,
                            logic bl, logic ds, logic slp, int k);
    logic acc_e, acc_i, rr, rcls;
    logic [31:0] s;
    @(negedge clk);
    exc_valid = ev; exc_code = ec; irq_pending = ip; irq_code = ic; irq_code_valid = icv;
    in_delay_slot = ds; asleep = slp;
    sr_in  = 32'h0000_8000 | (32'(k % 16) << 4) | (32'(k & 1) << 30) | (32'(bl) << 28) | 32'(k & 3);
    pc_in  = 32'h0C00_1000 + 32'(k) * 32'h24;
    vbr_in = 32'h8C00_0000 + 32'(k) * 32'h1000;
    r15_in = 32'h7FFF_0000 - 32'(k) * 4;
    #0.1 chk("R3", "irq_mask", 32'(irq_mask), 32'(k % 16));
    rr    = ev && bl && (ec != 12'h1E0);
    acc_e = ev && !rr;
    acc_i = !ev && ip && icv && !ds && (!bl || slp);
    if (acc_e || acc_i) begin
      e_ssr = sr_in; e_sgr = r15_in;
      e_spc = pc_in - (ds ? 32'd2 : 32'd0) + ((acc_e && ec == 12'h160) ? 32'd2 : 32'd0);
      s = sr_in | (32'd1 << 28) | (32'd1 << 29) | (32'd1 << 30);
      rcls = acc_e && (ec == 12'h000 || ec == 12'h020 || ec == 12'h140);
      if (rcls) s = (s & ~32'h0000_80F0) | 32'h0000_00F0;
      e_sr = s;
      if (acc_i) begin e_pc = vbr_in + 32'h600; e_int = ic; end
      else begin
        e_exp = ec;
        if (rcls) e_pc = 32'hA000_0000;
        else if (ec == 12'h040 || ec == 12'h060) e_pc = vbr_in + 32'h400;
        else e_pc = vbr_in + 32'h100;
      end
    end
    @(posedge clk); #1;
    check_all(acc_e || acc_i, rr, (acc_e || acc_i) && ds);
    @(negedge clk);
    exc_valid = 0; irq_pending = 0; irq_code_valid = 0; in_delay_slot = 0;
    @(posedge clk); #1;
    check_all(1'b0, 1'b0, 1'b0); // R9 hold
  endtask

  initial begin
    logic [11:0] codes [9] = '{12'h000, 12'h020, 12'h040, 12'h060, 12'h0A0,
                               12'h140, 12'h160, 12'h1E0, 12'h180};
    int k = 0;
    #1;
    check_all(1'b0, 1'b0, 1'b0); // R10 during reset
    #10 rst_n = 1;
    @(posedge clk); #1;
    check_all(1'b0, 1'b0, 1'b0); // R10 after release
    // exceptions with a competing interrupt (R1, R2, R5, R6, R7)
    for (int c = 0; c < 9; c++)
      for (int bl = 0; bl < 2; bl++)
        for (int ds = 0; ds < 2; ds++) begin
          event_step(1'b1, codes[c], 1'b1, 12'h300 + 12'(k), 1'b1,
                     1'(bl), 1'(ds), 1'(k & 1), k);
          k++;
        end
    // interrupts over blocking, sleep, delay slot, controller valid (R3, R8)
    for (int bl = 0; bl < 2; bl++)
      for (int slp = 0; slp < 2; slp++)
        for (int ds = 0; ds < 2; ds++)
          for (int v = 0; v < 2; v++) begin
            event_step(1'b0, 12'h000, 1'b1, 12'h200 + 12'(k * 32), 1'(v),
                       1'(bl), 1'(ds), 1'(slp), k);
            k++;
          end
    // nothing pending
    event_step(1'b0, 12'h0A0, 1'b0, 12'h3E0, 1'b1, 1'b0, 1'b0, 1'b0, k);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #100000;
    n_chk++; n_bad++;
    $display("FAIL R9 watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule